// File: doc/BRIEF.md
# Tiled (4,2) Counter Tree Multiplier

This block multiplies two 8-bit unsigned operands and returns the full 16-bit product. All partial-product rows are formed at once by AND gates. A tree of (4,2) counters then reduces them to two rows, and a parallel-prefix carry-propagate adder adds those two rows.

Each (4,2) counter is built from two full adders. Its internal carry passes sideways into the next higher column of the same tree level. That carry comes only from the first adder, so it never ripples along a row. The first level holds one row of counters for each group of four partial-product rows. A second level brings the four rows that result down to two.

The operands are captured in flip-flops at the block's input. The product is combinational from those flip-flops, so it is valid one clock cycle after the operands are presented.

Top module: `cnt42_mult8`

## Requirements
- R1: While rst_ni is low, the operand registers are cleared and p_o reads 0.
- R2: With reset released, p_o after a rising edge equals the product of the a_i and b_i values sampled at that edge. The latency is one cycle.
- R3: For every one of the 65,536 operand pairs, p_o equals the exact unsigned product, with no truncation. The largest case is 255 x 255 = 16'hFE01.
- R4: A zero in either operand gives p_o = 0.
- R5: A standalone (4,2) counter cell satisfies sum + 2*(carry + cout) = x[0] + x[1] + x[2] + x[3] + cin for all 32 input combinations. Here sum has weight 1, and carry and cout both have weight 2.
- R6: The cout output of a (4,2) counter cell depends only on x[2:0] and never on cin.
- R7: When a_i and b_i are held over consecutive edges, p_o does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Multiplicand, unsigned |
| b_i | input | 8 | Multiplier, unsigned |
| p_o | output | 16 | Unsigned product, one cycle after operand capture |

## Verification
A wrong sideways carry, or a wrong operand alignment, inside one counter row corrupts p_o only for those operand pairs that exercise that column. It appears in the very next cycle after capture, and it is usually off by a power of two. Sweeping all operand pairs back to back, one per cycle, exposes any such fault within at most 65,536 cycles. A fault in the counter cell's carry split might cancel out in the tree. It is therefore also checked directly on an isolated cell over its full input space, including the rule that cout does not depend on cin.

// File: rtl/mul42_pkg.sv
package mul42_pkg;
  localparam int unsigned OP_W    = 8;
  localparam int unsigned GRP_H   = 4;  // rows folded by one counter row
  localparam int unsigned PROD_W  = 2 * OP_W;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i ^ c_i;
  assign co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/cnt42_cell.sv
module cnt42_cell (
  input  logic [3:0] x_i,
  input  logic       cin_i,
  output logic       sum_o,
  output logic       carry_o,
  output logic       cout_o
);
  logic s_first;

  // first adder: three inputs, sideways carry; cin never reaches cout
  fa_cell i_fa_lo (
    .a_i (x_i[0]),
    .b_i (x_i[1]),
    .c_i (x_i[2]),
    .s_o (s_first),
    .co_o(cout_o)
  );

  fa_cell i_fa_hi (
    .a_i (s_first),
    .b_i (x_i[3]),
    .c_i (cin_i),
    .s_o (sum_o),
    .co_o(carry_o)
  );
endmodule

// File: rtl/cnt42_row.sv
// One row of tiled (4,2) counters. Four aligned W-bit rows in, two out.
// Weight beyond bit W-1 is discarded: the result is exact modulo 2**W.
module cnt42_row #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] r0_i,
  input  logic [W-1:0] r1_i,
  input  logic [W-1:0] r2_i,
  input  logic [W-1:0] r3_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W:0]   side_c;
  logic [W-1:0] col_carry;

  assign side_c[0] = 1'b0;

  for (genvar j = 0; j < W; j++) begin : g_col
    cnt42_cell i_cell (
      .x_i    ({r3_i[j], r2_i[j], r1_i[j], r0_i[j]}),
      .cin_i  (side_c[j]),
      .sum_o  (sum_o[j]),
      .carry_o(col_carry[j]),
      .cout_o (side_c[j+1])
    );
  end

  assign carry_o = {col_carry[W-2:0], 1'b0};
endmodule

// File: rtl/pp_gen.sv
module pp_gen #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]        a_i,
  input  logic [N-1:0]        b_i,
  output logic [N-1:0][N-1:0] pp_o
);
  for (genvar k = 0; k < N; k++) begin : g_row
    assign pp_o[k] = a_i & {N{b_i[k]}};
  end
endmodule

// File: rtl/prefix_adder.sv
// Kogge-Stone carry-propagate adder, result modulo 2**W.
module prefix_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  localparam int unsigned LVL = $clog2(W);

  logic [LVL:0][W-1:0] g;
  logic [LVL:0][W-1:0] p;

  assign g[0] = a_i & b_i;
  assign p[0] = a_i ^ b_i;

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int unsigned D = 1 << l;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign g[l+1][i] = g[l][i] | (p[l][i] & g[l][i-D]);
        assign p[l+1][i] = p[l][i] & p[l][i-D];
      end else begin : g_pass
        assign g[l+1][i] = g[l][i];
        assign p[l+1][i] = p[l][i];
      end
    end
  end

  assign s_o = p[0] ^ {g[LVL][W-2:0], 1'b0};
endmodule

// File: rtl/cnt42_mult8.sv
module cnt42_mult8
  import mul42_pkg::*;
#(
  parameter int unsigned N = OP_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o
);
  localparam int unsigned PW  = 2 * N;
  localparam int unsigned NG  = N / GRP_H;       // first-level rows (two)
  localparam int unsigned W1  = N + GRP_H;       // group sum fits, top column empty

  logic [N-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  logic [N-1:0][N-1:0] pp;

  pp_gen #(.N(N)) i_pp (
    .a_i (a_q),
    .b_i (b_q),
    .pp_o(pp)
  );

  // level 1: each group of four rows folded in its own column space
  logic [NG-1:0][W1-1:0] l1_sum, l1_carry;

  for (genvar g = 0; g < NG; g++) begin : g_l1
    logic [GRP_H-1:0][W1-1:0] row;
    for (genvar k = 0; k < GRP_H; k++) begin : g_align
      assign row[k] = W1'(pp[g*GRP_H+k]) << k;
    end
    cnt42_row #(.W(W1)) i_row (
      .r0_i   (row[0]),
      .r1_i   (row[1]),
      .r2_i   (row[2]),
      .r3_i   (row[3]),
      .sum_o  (l1_sum[g]),
      .carry_o(l1_carry[g])
    );
  end

  // level 2: four rows from the two groups, realigned to product weight
  logic [PW-1:0] l2_in0, l2_in1, l2_in2, l2_in3;
  logic [PW-1:0] l2_sum, l2_carry;

  assign l2_in0 = PW'(l1_sum[0]);
  assign l2_in1 = PW'(l1_carry[0]);
  assign l2_in2 = PW'(l1_sum[1])   << GRP_H;
  assign l2_in3 = PW'(l1_carry[1]) << GRP_H;

  cnt42_row #(.W(PW)) i_row_l2 (
    .r0_i   (l2_in0),
    .r1_i   (l2_in1),
    .r2_i   (l2_in2),
    .r3_i   (l2_in3),
    .sum_o  (l2_sum),
    .carry_o(l2_carry)
  );

  prefix_adder #(.W(PW)) i_cpa (
    .a_i(l2_sum),
    .b_i(l2_carry),
    .s_o(p_o)
  );
endmodule

// File: rtl/mul42_chk.sv
module mul42_chk #(
  parameter int unsigned N = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic [2*N-1:0] p_o
);
  localparam logic [2*N-1:0] PMAX = (2*N)'(((1 << N) - 1) * ((1 << N) - 1));

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> p_o == '0);

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> p_o == (2*N)'($past(a_i)) * (2*N)'($past(b_i)));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_o <= PMAX);

  a_r4_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(a_i) == '0 || $past(b_i) == '0)) |-> p_o == '0);

  a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(a_i) && $stable(b_i)) |=> $stable(p_o));
endmodule

bind cnt42_mult8 mul42_chk #(.N(N)) i_mul42_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .a_i   (a_i),
  .b_i   (b_i),
  .p_o   (p_o)
);

// File: tb/test_cnt42_mult8.sv
module test_cnt42_mult8;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_CYC    = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  a_i = '0, b_i = '0;
  logic [15:0] p_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  cnt42_mult8 i_cnt42_mult8 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (a_i),
    .b_i   (b_i),
    .p_o   (p_o)
  );

  // standalone counter cell
  logic [3:0] cx = '0;
  logic       cci = 1'b0;
  logic       cs, cc, cco;

  cnt42_cell i_cell (
    .x_i    (cx),
    .cin_i  (cci),
    .sum_o  (cs),
    .carry_o(cc),
    .cout_o (cco)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > MAX_CYC) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, MAX_CYC);
      finish_run();
    end
  end

  task automatic t_reset();
    a_i = 8'd200; b_i = 8'd99;
    repeat (3) @(negedge clk_i);
    check("R1 product held at 0 in reset", int'(p_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    a_i = '0; b_i = '0;
    @(negedge clk_i);
  endtask

  task automatic t_latency();
    @(negedge clk_i);
    a_i = 8'd13; b_i = 8'd11;
    #1;
    check("R2 no change before edge", int'(p_o), 0);
    @(negedge clk_i);
    check("R2 one-cycle latency", int'(p_o), 143);
  endtask

  task automatic t_corners();
    @(negedge clk_i); a_i = 8'd255; b_i = 8'd255;
    @(negedge clk_i); check("R3 max product 0xFE01", int'(p_o), 65025);
    a_i = 8'd0; b_i = 8'd255;
    @(negedge clk_i); check("R4 zero multiplicand", int'(p_o), 0);
    a_i = 8'd173; b_i = 8'd0;
    @(negedge clk_i); check("R4 zero multiplier", int'(p_o), 0);
    a_i = 8'd128; b_i = 8'd128;
    @(negedge clk_i); check("R3 top bits only", int'(p_o), 16384);
  endtask

  task automatic t_hold();
    @(negedge clk_i); a_i = 8'd91; b_i = 8'd237;
    @(negedge clk_i); check("R7 held operands first", int'(p_o), 91 * 237);
    @(negedge clk_i); check("R7 held operands second", int'(p_o), 91 * 237);
    @(negedge clk_i); check("R7 held operands third", int'(p_o), 91 * 237);
  endtask

  task automatic t_exhaustive();
    int exp_prev;
    a_i = 8'd0; b_i = 8'd0;
    @(negedge clk_i);
    exp_prev = 0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        a_i = 8'(a); b_i = 8'(b);
        @(negedge clk_i);
        exp_prev = a * b;
        check("R3 exhaustive pair", int'(p_o), exp_prev);
      end
    end
  endtask

  task automatic t_cell();
    for (int v = 0; v < 32; v++) begin
      int in_sum, out_sum;
      logic co_first;
      cx = 4'(v); cci = v[4];
      #1;
      in_sum  = int'(cx[0]) + int'(cx[1]) + int'(cx[2]) + int'(cx[3]) + int'(cci);
      out_sum = int'(cs) + 2 * (int'(cc) + int'(cco));
      check("R5 counter weighted sum", out_sum, in_sum);
      co_first = cco;
      cci = ~cci;
      #1;
      check("R6 cout independent of cin", int'(cco), int'(co_first));
      check("R6 cout is majority of x[2:0]", int'(cco),
            int'((cx[0] & cx[1]) | (cx[0] & cx[2]) | (cx[1] & cx[2])));
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_corners();
    t_hold();
    t_cell();
    t_exhaustive();
    finish_run();
  end
endmodule